// File: doc/BRIEF.md
# Received-Pause Transmit Hold Timer

This block holds an Ethernet MAC transmitter quiet after the receiver has recognised a flow-control pause frame. A one-cycle detection pulse, together with the requested pause length in slot times, starts the sequence. The block then raises a graceful-stop request towards the transmit path. It waits until that path reports it is idle, and then marks the completed stop with a single-cycle interrupt pulse. From that point it counts slot-time ticks until the requested number has elapsed, and then withdraws the stop request so that data frames may flow again.

The slot-time tick comes from outside; it is the same tick that paces the half-duplex collision backoff, so the pause length is expressed in slot-time units. Ticks that arrive before the stop has completed are not counted. A receive-pause status output stays high for the whole hold, from the stop request to the release. When a further pause frame arrives during a hold, the count restarts from zero with the newly supplied length.

Top module: `pause_hold_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stop_req_o`, `stop_done_irq_o` and `rx_pause_o` are all 0.
- R2: A `pause_det_i` pulse while idle makes `stop_req_o` and `rx_pause_o` go to 1 on the following clock edge, with `stop_done_irq_o` still 0.
- R3: While the stop is requested but `tx_idle_i` is 0, `stop_req_o` stays 1, no interrupt is produced, and `slot_tick_i` pulses are not counted toward the pause length.
- R4: The first edge at which `tx_idle_i` is 1 during a pending stop makes `stop_done_irq_o` 1 for exactly one cycle; there is exactly one such pulse per hold.
- R5: With captured length L > 0, `stop_req_o` and `rx_pause_o` fall on the clock edge that samples the L-th `slot_tick_i` pulse after the stop completed, and not before.
- R6: With captured length 0, `stop_req_o` and `rx_pause_o` fall on the same edge at which `stop_done_irq_o` rises.
- R7: A `pause_det_i` pulse during the counting phase restarts the count from zero with the new `pause_len_i`, produces no further interrupt, and a new length of 0 releases the hold on that edge.
- R8: The length is sampled from `pause_len_i` only in the cycle that `pause_det_i` is 1; later changes of `pause_len_i` have no effect on the hold.
- R9: While idle, `tx_idle_i` and `slot_tick_i` have no effect: all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_det_i | input | 1 | One-cycle pulse: a pause frame was recognised |
| pause_len_i | input | DUR_W | Requested pause length in slot times, sampled with the detection pulse |
| slot_tick_i | input | 1 | One-cycle pulse once per slot time |
| tx_idle_i | input | 1 | Transmit path has stopped sending data frames |
| stop_req_o | output | 1 | Graceful-stop request to the transmitter |
| stop_done_irq_o | output | 1 | One-cycle pulse when the requested stop has completed |
| rx_pause_o | output | 1 | Transmitter held because of a received pause frame |

## Verification
The bench builds the block with DUR_W = 4, so every possible length from 0 to 15 can be swept. Each length is combined with a different number of early ticks and a different stop latency. With 4 bits the counter reaches its all-ones value, which exercises the terminal compare at the top of its range. The same configuration keeps the restart, zero-length and ignored-input cases short enough to check on every cycle around them.

// File: rtl/pause_hold_pkg.sv
package pause_hold_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_STOPPING = 2'd1,
        PH_HOLD     = 2'd2
    } ph_state_e;

    typedef struct packed {
        logic load_len;
        logic ctr_clr;
        logic ctr_inc;
        logic done_pulse;
    } ph_ctrl_s;

    // True when one more tick brings the count to the limit.
    function automatic logic ph_hits_limit(input logic [31:0] cnt, input logic [31:0] lim);
        return (cnt + 32'd1) == lim;
    endfunction

endpackage

// File: rtl/phold_dur_reg.sv
module phold_dur_reg #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DUR_W-1:0] len_i,
    output logic [DUR_W-1:0] dur_o,
    output logic [DUR_W-1:0] eff_o
);
    logic [DUR_W-1:0] dur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dur_q <= '0;
        end else if (load_i) begin
            dur_q <= len_i;
        end
    end

    assign dur_o = dur_q;
    // A length arriving in this cycle overrides the held one.
    assign eff_o = load_i ? len_i : dur_q;

    assert_len_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(dur_q));

endmodule

// File: rtl/phold_slot_ctr.sv
module phold_slot_ctr #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [DUR_W-1:0] limit_i,
    output logic [DUR_W-1:0] cnt_o,
    output logic             last_o
);
    import pause_hold_pkg::*;

    logic [DUR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = inc_i && ph_hits_limit(32'(cnt_q), 32'(limit_i));

    assert_clr_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/phold_fsm.sv
module phold_fsm (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      det_i,
    input  logic                      tx_idle_i,
    input  logic                      tick_i,
    input  logic                      eff_zero_i,
    input  logic                      last_i,
    output pause_hold_pkg::ph_state_e state_o,
    output pause_hold_pkg::ph_ctrl_s  ctrl_o,
    output logic                      irq_o
);
    import pause_hold_pkg::*;

    ph_state_e state_q, state_d;
    ph_ctrl_s  ctrl;
    logic      irq_q;

    always_comb begin
        state_d         = state_q;
        ctrl            = '0;
        ctrl.load_len   = det_i;
        unique case (state_q)
            PH_IDLE: begin
                ctrl.ctr_clr = 1'b1;
                if (det_i) state_d = PH_STOPPING;
            end
            PH_STOPPING: begin
                ctrl.ctr_clr = 1'b1;
                if (tx_idle_i) begin
                    ctrl.done_pulse = 1'b1;
                    state_d = eff_zero_i ? PH_IDLE : PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (det_i) begin
                    ctrl.ctr_clr = 1'b1;
                    if (eff_zero_i) state_d = PH_IDLE;
                end else begin
                    ctrl.ctr_inc = tick_i;
                    if (last_i) state_d = PH_IDLE;
                end
            end
            default: begin
                state_d = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= ctrl.done_pulse;
        end
    end

    assign state_o = state_q;
    assign ctrl_o  = ctrl;
    assign irq_o   = irq_q;

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);
    assert_irq_after_req_R4: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(state_q == PH_STOPPING));
    assert_req_from_det_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_IDLE && $past(state_q == PH_IDLE)) |-> $past(det_i));

endmodule

// File: rtl/pause_hold_timer.sv
module pause_hold_timer #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pause_det_i,
    input  logic [DUR_W-1:0] pause_len_i,
    input  logic             slot_tick_i,
    input  logic             tx_idle_i,
    output logic             stop_req_o,
    output logic             stop_done_irq_o,
    output logic             rx_pause_o
);
    import pause_hold_pkg::*;

    ph_state_e        state;
    ph_ctrl_s         ctrl;
    logic [DUR_W-1:0] dur_q;
    logic [DUR_W-1:0] dur_eff;
    logic [DUR_W-1:0] cnt;
    logic             last_tick;
    logic             irq;

    phold_dur_reg #(.DUR_W(DUR_W)) dur_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (ctrl.load_len),
        .len_i  (pause_len_i),
        .dur_o  (dur_q),
        .eff_o  (dur_eff)
    );

    phold_slot_ctr #(.DUR_W(DUR_W)) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (ctrl.ctr_clr),
        .inc_i   (ctrl.ctr_inc),
        .limit_i (dur_eff),
        .cnt_o   (cnt),
        .last_o  (last_tick)
    );

    phold_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .det_i      (pause_det_i),
        .tx_idle_i  (tx_idle_i),
        .tick_i     (slot_tick_i),
        .eff_zero_i (dur_eff == '0),
        .last_i     (last_tick),
        .state_o    (state),
        .ctrl_o     (ctrl),
        .irq_o      (irq)
    );

    assign stop_req_o      = (state != PH_IDLE);
    assign rx_pause_o      = (state != PH_IDLE);
    assign stop_done_irq_o = irq;

    assert_cnt_below_len_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PH_HOLD) |-> (cnt < dur_q));
    assert_release_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_req_o) |-> (stop_done_irq_o || $past(slot_tick_i) || $past(pause_det_i)));
    assert_zero_len_release_R6: assert property (@(posedge clk) disable iff (rst)
        (stop_done_irq_o && dur_q == '0) |-> !stop_req_o);

endmodule

// File: tb/pause_hold_timer_tb_top.sv
`timescale 1ns/1ps
module pause_hold_timer_tb_top;
    localparam int DUR_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             det = 1'b0;
    logic [DUR_W-1:0] len = '0;
    logic             tick = 1'b0;
    logic             idle = 1'b0;
    logic             stop_req, irq, rxp;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pause_hold_timer #(.DUR_W(DUR_W)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .pause_det_i     (det),
        .pause_len_i     (len),
        .slot_tick_i     (tick),
        .tx_idle_i       (idle),
        .stop_req_o      (stop_req),
        .stop_done_irq_o (irq),
        .rx_pause_o      (rxp)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {stop_req, irq, rxp};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {stop,irq,rx} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Full hold with length L, early ticks and a stop latency.
    task automatic run_pause(input int L, input int pre_ticks, input int delay);
        det = 1'b1; len = DUR_W'(L);
        step();
        det = 1'b0; len = ~DUR_W'(L); // R8: later length changes must be ignored
        chk("R2", 3'b101);
        for (int i = 0; i < pre_ticks; i++) begin
            tick = 1'b1; step(); tick = 1'b0;
            chk("R3", 3'b101);
        end
        for (int i = 0; i < delay; i++) begin
            step();
            chk("R3", 3'b101);
        end
        idle = 1'b1; step(); idle = 1'b0;
        if (L == 0) chk("R6", 3'b010);
        else        chk("R4", 3'b111);
        for (int k = 1; k <= L; k++) begin
            step();
            chk("R4", 3'b101);
            tick = 1'b1; step(); tick = 1'b0;
            if (k < L) chk("R5", 3'b101);
            else       chk("R5", 3'b000);
        end
        step();
        chk("R8", 3'b000);
    endtask

    initial begin
        repeat (2) step();
        chk("R1", 3'b000);
        rst = 1'b0;
        chk("R1", 3'b000);
        step();
        chk("R1", 3'b000);

        // R9: transmitter-idle and ticks while idle do nothing
        idle = 1'b1; tick = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R9", 3'b000);
        end
        idle = 1'b0; tick = 1'b0;

        // Sweep every length with varied early ticks and latency
        for (int L = 0; L < (1 << DUR_W); L++) begin
            run_pause(L, L % 3, L % 4);
        end

        // R7: restart during counting with a new length
        det = 1'b1; len = 4'd6; step(); det = 1'b0;
        idle = 1'b1; step(); idle = 1'b0;
        chk("R7", 3'b111);
        for (int k = 0; k < 2; k++) begin
            tick = 1'b1; step(); tick = 1'b0;
            chk("R7", 3'b101);
        end
        det = 1'b1; len = 4'd3; step(); det = 1'b0; len = 4'd15;
        chk("R7", 3'b101);
        for (int k = 1; k <= 3; k++) begin
            tick = 1'b1; step(); tick = 1'b0;
            if (k < 3) chk("R7", 3'b101);
            else       chk("R7", 3'b000);
        end

        // R7: restart with length zero releases at once
        det = 1'b1; len = 4'd9; step(); det = 1'b0;
        idle = 1'b1; step(); idle = 1'b0;
        chk("R7", 3'b111);
        tick = 1'b1; step(); tick = 1'b0;
        chk("R7", 3'b101);
        det = 1'b1; len = 4'd0; step(); det = 1'b0;
        chk("R7", 3'b000);
        step();
        chk("R7", 3'b000);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule